// File: doc/BRIEF.md
# Relative Branch Decision Unit

This block takes a 16-bit instruction word, the program counter that already points past that word, and the four condition flags. It decides whether the word is a conditional or unconditional relative branch and whether that branch is taken. It then produces the next program counter. The upper byte of the word selects the branch condition. The lower byte is a signed word offset. Because instruction addresses are always even, the offset is doubled before it is added to the incoming PC.

The decision and the target are computed combinationally and captured in one output register stage. Results therefore appear one clock after the inputs are presented. A word whose upper byte is not one of the fifteen branch codes passes the PC through unchanged and reports not-taken. Flag generation, instruction fetch and absolute jumps belong to neighbouring blocks.

Top module: `rel_branch_unit`

## Requirements
- R1: While rst_ni is low, taken_o is 0 and next_pc_o is 0.
- R2: The branch code is instr_i[15:8] and the offset is instr_i[7:0], read as two's complement. Outputs reflect the inputs present at the previous rising clock edge.
- R3: For a taken branch, next_pc_o equals pc_i + 2*offset modulo 2^PC_W. For example, with pc_i = 0x0106 and offset 0xFD (-3), next_pc_o is 0x0100.
- R4: For a branch that is not taken, next_pc_o equals pc_i.
- R5: Code 0x01 is unconditional and is always taken, whatever the flags are.
- R6: Flags are packed as flags_i = {N, Z, V, C}, with N in bit 3. Code 0x03 is taken when Z=1 and code 0x02 is taken when Z=0. Code 0x87 is taken when C=1 and code 0x86 is taken when C=0.
- R7: The signed comparison codes test N^V. Code 0x05 is taken on N^V. Code 0x04 is taken on !(N^V). Code 0x06 is taken on !(Z|(N^V)). Code 0x07 is taken on Z|(N^V).
- R8: Code 0x80 is taken on N=0 and code 0x81 on N=1. Code 0x84 is taken on V=0 and code 0x85 on V=1.
- R9: The unsigned comparison codes test C and Z. Code 0x82 is taken on !(C|Z). Code 0x83 is taken on C|Z.
- R10: Any other code (0x00, 0x08 to 0x7F, 0x88 to 0xFF) is not a branch. For such a code, taken_o is 0 and next_pc_o equals pc_i, whatever the flags and offset are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Instruction word: code in [15:8], offset in [7:0] |
| pc_i | input | PC_W | PC already advanced past the instruction word |
| flags_i | input | 4 | Condition flags {N, Z, V, C} |
| taken_o | output | 1 | Branch taken, registered |
| next_pc_o | output | PC_W | Next program counter, registered |

## Verification
The hardest case to reach is a code that sits next to a branch code but is not one, such as 0x00, 0x08, 0x7F or 0x88, paired with flags that would make a neighbouring branch taken. Only such a pairing shows whether decoding is loose. The stimulus therefore sweeps all 256 upper-byte values against all 16 flag combinations, with a nonzero offset, so any false decode moves the PC. A second sweep runs every offset through the unconditional code to cover sign extension and wraparound at both ends of the address space.

// File: rtl/rel_branch_pkg.sv
package rel_branch_pkg;
  typedef enum logic [3:0] {
    COND_NONE,
    COND_ALWAYS,
    COND_NE,
    COND_EQ,
    COND_GE_S,
    COND_LT_S,
    COND_GT_S,
    COND_LE_S,
    COND_POS,
    COND_NEG,
    COND_HI_U,
    COND_LS_U,
    COND_VCLR,
    COND_VSET,
    COND_CCLR,
    COND_CSET
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  localparam int unsigned CODE_W = 8;
endpackage

// File: rtl/rel_branch_decode.sv
module rel_branch_decode
  import rel_branch_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output cond_e             cond_o
);
  // two code groups: 0x01..0x07 (signed/equality), 0x80..0x87 (single-flag/unsigned)
  always_comb begin
    cond_o = COND_NONE;
    if (code_i[7:3] == 5'b00000) begin
      unique case (code_i[2:0])
        3'd1: cond_o = COND_ALWAYS;
        3'd2: cond_o = COND_NE;
        3'd3: cond_o = COND_EQ;
        3'd4: cond_o = COND_GE_S;
        3'd5: cond_o = COND_LT_S;
        3'd6: cond_o = COND_GT_S;
        3'd7: cond_o = COND_LE_S;
        default: cond_o = COND_NONE;
      endcase
    end else if (code_i[7:3] == 5'b10000) begin
      unique case (code_i[2:0])
        3'd0: cond_o = COND_POS;
        3'd1: cond_o = COND_NEG;
        3'd2: cond_o = COND_HI_U;
        3'd3: cond_o = COND_LS_U;
        3'd4: cond_o = COND_VCLR;
        3'd5: cond_o = COND_VSET;
        3'd6: cond_o = COND_CCLR;
        default: cond_o = COND_CSET;
      endcase
    end
  end
endmodule

// File: rtl/rel_branch_cond.sv
module rel_branch_cond
  import rel_branch_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   taken_o
);
  logic lt_s;
  assign lt_s = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (cond_i)
      COND_ALWAYS: taken_o = 1'b1;
      COND_NE:     taken_o = ~flags_i.z;
      COND_EQ:     taken_o = flags_i.z;
      COND_GE_S:   taken_o = ~lt_s;
      COND_LT_S:   taken_o = lt_s;
      COND_GT_S:   taken_o = ~(flags_i.z | lt_s);
      COND_LE_S:   taken_o = flags_i.z | lt_s;
      COND_POS:    taken_o = ~flags_i.n;
      COND_NEG:    taken_o = flags_i.n;
      COND_HI_U:   taken_o = ~(flags_i.c | flags_i.z);
      COND_LS_U:   taken_o = flags_i.c | flags_i.z;
      COND_VCLR:   taken_o = ~flags_i.v;
      COND_VSET:   taken_o = flags_i.v;
      COND_CCLR:   taken_o = ~flags_i.c;
      COND_CSET:   taken_o = flags_i.c;
      default:     taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rel_branch_target.sv
module rel_branch_target #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 8
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int unsigned EXT_W = PC_W - OFS_W - 1;

  logic [PC_W-1:0] disp;

  // word offset -> byte displacement: sign-extend, then shift left by one
  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i, 1'b0};
    end else begin : g_trunc
      assign disp = {ofs_i[PC_W-2:0], 1'b0};
    end
  endgenerate

  assign target_o = pc_i + disp;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rel_branch_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [15:0]     instr_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [3:0]      flags_i,
  output logic            taken_o,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int unsigned OFS_W = 16 - CODE_W;

  cond_e           cond;
  logic            taken_d;
  logic [PC_W-1:0] target;

  rel_branch_decode u_decode (
    .code_i (instr_i[15:OFS_W]),
    .cond_o (cond)
  );

  rel_branch_cond u_cond (
    .cond_i  (cond),
    .flags_i (flags_t'(flags_i)),
    .taken_o (taken_d)
  );

  rel_branch_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_target (
    .pc_i     (pc_i),
    .ofs_i    (instr_i[OFS_W-1:0]),
    .target_o (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      taken_o   <= taken_d;
      next_pc_o <= taken_d ? target : pc_i;
    end
  end
endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [15:0]     instr_i,
  input logic [PC_W-1:0] pc_i,
  input logic [3:0]      flags_i,
  input logic            taken_o,
  input logic [PC_W-1:0] next_pc_o
);
  logic known_code;
  assign known_code = (instr_i[15:8] inside {[8'h01:8'h07], [8'h80:8'h87]});

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear : assert (!taken_o && next_pc_o == '0);
    end
  end

  a_r10_non_branch_pass : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_code |=> (!taken_o && next_pc_o == $past(pc_i)));

  a_r5_always_taken : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:8] == 8'h01) |=> taken_o);

  a_r6_eq_follows_z : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:8] == 8'h03) |=> (taken_o == $past(flags_i[2])));

  a_r4_not_taken_holds_pc : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (taken_o || next_pc_o == $past(pc_i)));

  a_r3_parity_kept : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (next_pc_o[0] == $past(pc_i[0])));

  a_r3_zero_offset : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[7:0] == 8'h00) |=> (next_pc_o == $past(pc_i)));
endmodule

bind rel_branch_unit rel_branch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .pc_i      (pc_i),
  .flags_i   (flags_i),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o)
);

// File: tb/rel_branch_unit_tb.sv
module rel_branch_unit_tb;
  localparam int unsigned PC_W = 16;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [15:0]     instr_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [3:0]      flags_i = '0;
  logic            taken_o;
  logic [PC_W-1:0] next_pc_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rel_branch_unit #(.PC_W(PC_W)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .flags_i   (flags_i),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o)
  );

  function automatic bit exp_taken(input logic [7:0] code, input logic [3:0] f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (code)
      8'h01: return 1'b1;
      8'h02: return !z;
      8'h03: return z;
      8'h04: return !(n ^ v);
      8'h05: return n ^ v;
      8'h06: return !(z || (n ^ v));
      8'h07: return z || (n ^ v);
      8'h80: return !n;
      8'h81: return n;
      8'h82: return !(c || z);
      8'h83: return c || z;
      8'h84: return !v;
      8'h85: return v;
      8'h86: return !c;
      8'h87: return c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] code);
    case (code)
      8'h01: return "R5";
      8'h02, 8'h03, 8'h86, 8'h87: return "R6";
      8'h04, 8'h05, 8'h06, 8'h07: return "R7";
      8'h80, 8'h81, 8'h84, 8'h85: return "R8";
      8'h82, 8'h83: return "R9";
      default: return "R10";
    endcase
  endfunction

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic apply_check(input logic [15:0] ins, input logic [PC_W-1:0] pc,
                             input logic [3:0] fl, input string req);
    bit              et;
    logic [PC_W-1:0] ep;
    int              so;
    instr_i = ins; pc_i = pc; flags_i = fl;
    et = exp_taken(ins[15:8], fl);
    so = int'($signed(ins[7:0]));
    ep = et ? PC_W'(int'(pc) + 2 * so) : pc;
    @(posedge clk_i);
    @(negedge clk_i);
    n_cmp++;
    if (taken_o !== et || next_pc_o !== ep) begin
      n_bad++;
      $display("FAIL %s instr=%h pc=%h flags=%b: got taken=%b pc=%h, exp taken=%b pc=%h",
               req, ins, pc, fl, taken_o, next_pc_o, et, ep);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    n_cmp++;
    if (taken_o !== 1'b0 || next_pc_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got taken=%b pc=%h, exp 0 0000", taken_o, next_pc_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R10 R5..R9: every code byte against every flag set, nonzero offset
    for (int code = 0; code < 256; code++) begin
      for (int f = 0; f < 16; f++) begin
        apply_check({8'(code), 8'h05}, 16'h2468 + 16'(code * 2), 4'(f), req_of(8'(code)));
      end
    end

    // R3: every offset through the unconditional code
    for (int o = 0; o < 256; o++) begin
      apply_check({8'h01, 8'(o)}, 16'h0100, 4'h0, "R3");
    end
    // R3: wraparound at both ends
    apply_check({8'h01, 8'h80}, 16'h0010, 4'h0, "R3");
    apply_check({8'h01, 8'h7F}, 16'hFFF0, 4'h0, "R3");
    // R3: three-word backward loop
    apply_check({8'h01, 8'hFD}, 16'h0106, 4'h0, "R3");
    // R4: not-taken conditional keeps PC despite large offset
    apply_check({8'h03, 8'h7F}, 16'h4000, 4'b0000, "R4");
    apply_check({8'h87, 8'h80}, 16'h4000, 4'b1110, "R4");

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule